// File: doc/BRIEF.md
# Periodic Tick Timer with Interrupt Request

This block divides a system clock down to a fixed 50 Hz tick (a 20 ms period) and signals each tick to software in two ways: a sticky ready flag that software can poll, and a one-cycle interrupt request at priority level 13, sent only when interrupts are enabled. The system clock frequency and the tick rate are parameters, and a prescaler counter is sized from their ratio.

Software reaches the block through a small bus port. The two low address bits select one of four register offsets. Offset 0 reads back zero. Any access at offset 1 restarts the tick period. Offset 2 returns the status word. A write to offset 3 loads the interrupt enable, restarts the period, and clears the ready flag only when data bit 13 is set. Read data is registered and appears on the cycle after the access.

Top module: `periodic_tick_timer`

## Requirements
- R1: With PERIOD = SYS_CLK_HZ / TICK_HZ, a tick occurs on the PERIOD-th clock edge after reset is released or after a period restart, and every PERIOD edges after that.
- R2: Reset (synchronous, active high) clears the interrupt enable and the ready flag, sets the period counter to zero, and drives read data and the interrupt request low.
- R3: A read at offset 0 returns zero. Writes at offsets 0 and 2 and reads at offset 3 change no flag.
- R4: Any access (read or write) at offset 1 restarts the period counter from zero, leaves both flags as they were, and returns zero when read.
- R5: A read at offset 2 returns the ready flag in bit 3 and the interrupt enable in bit 0; all other bits read zero.
- R6: A write at offset 3 restarts the period counter, sets the interrupt enable from data bit 0, and clears the ready flag if and only if data bit 13 is set.
- R7: Every tick sets the ready flag, whether or not interrupts are enabled.
- R8: A tick with the interrupt enable set (as held before that edge) raises the interrupt request for exactly one cycle; the level output always reads 13. With the enable clear no request is raised.
- R9: If a tick and a ready-clearing write at offset 3 fall on the same edge, the ready flag ends set.
- R10: Read data is registered: it shows the selected value on the cycle after a read access and is zero on any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_req | output | 1 | One-cycle interrupt request per enabled tick |
| irq_level | output | 4 | Priority level of the request (13) |

## Verification
A vector table drives every offset with both reads and writes, using all-ones data on the ignored offsets so that any stray decode would flip a flag visible in the next status read. Directed runs then time the tick from a reset, from an offset 1 restart and from an offset 3 write, which tells a correct prescaler apart from one off by a cycle in either direction. Control writes with and without bit 13, one landing on the very edge of a tick, separate the clear-on-bit-13 rule and the tick-wins priority from simpler clear-on-write schemes, and a run with the enable clear shows that ready still sets while no request leaves the block.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int ADDR_W = 2;
  localparam int DATA_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    OFS_ZERO    = 2'd0,
    OFS_RESTART = 2'd1,
    OFS_STATUS  = 2'd2,
    OFS_CONTROL = 2'd3
  } tt_offset_e;

  // status word layout
  localparam int BIT_ENABLE = 0;
  localparam int BIT_READY  = 3;
  // control write: clears ready when set
  localparam int BIT_CLEAR  = 13;

  typedef struct packed {
    logic ready;
    logic enable;
  } tt_flags_t;

  typedef struct packed {
    logic             restart;
    logic             ctl_wr;
    logic             rd;
    tt_offset_e       rd_sel;
  } tt_decode_t;

endpackage

// File: rtl/tt_decode.sv
module tt_decode
  import tick_timer_pkg::*;
(
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output tt_decode_t        dec
);

  tt_offset_e ofs;

  always_comb begin
    ofs         = tt_offset_e'(addr);
    dec.restart = 1'b0;
    dec.ctl_wr  = 1'b0;
    dec.rd      = sel & ~we;
    dec.rd_sel  = ofs;
    if (sel) begin
      unique case (ofs)
        OFS_RESTART: dec.restart = 1'b1;
        OFS_CONTROL: begin
          if (we) begin
            dec.restart = 1'b1;
            dec.ctl_wr  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int PERIOD = 2_000_000,
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic             tick,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick  = (cnt_q == LAST);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tt_flags.sv
module tt_flags
  import tick_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  output tt_flags_t         flags,
  output logic              irq
);

  tt_flags_t flags_q;
  logic      irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      // request uses the enable held before this edge
      irq_q <= tick & flags_q.enable;
      if (ctl_wr) begin
        flags_q.enable <= wdata[BIT_ENABLE];
      end
      // a tick on the same edge outranks the clear
      if (tick) begin
        flags_q.ready <= 1'b1;
      end else if (ctl_wr && wdata[BIT_CLEAR]) begin
        flags_q.ready <= 1'b0;
      end
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;

endmodule

// File: rtl/tt_readback.sv
module tt_readback
  import tick_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  tt_offset_e        rd_sel,
  input  tt_flags_t         flags,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    word = '0;
    if (rd_sel == OFS_STATUS) begin
      word[BIT_READY]  = flags.ready;
      word[BIT_ENABLE] = flags.enable;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd ? word : '0;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int SYS_CLK_HZ = 100_000_000,
  parameter int TICK_HZ    = 50,
  parameter int IRQ_LVL_W  = 4,
  parameter int IRQ_LEVEL  = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [1:0]           bus_addr,
  input  logic [15:0]          bus_wdata,
  output logic [15:0]          bus_rdata,
  output logic                 irq_req,
  output logic [IRQ_LVL_W-1:0] irq_level
);

  localparam int PERIOD = SYS_CLK_HZ / TICK_HZ;
  localparam int CNT_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  tt_decode_t       dec;
  tt_flags_t        flags;
  logic             tick;
  logic [CNT_W-1:0] count;

  tt_decode u_dec (
    .sel  (bus_sel),
    .we   (bus_we),
    .addr (bus_addr),
    .dec  (dec)
  );

  tt_prescaler #(.PERIOD(PERIOD)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (dec.restart),
    .tick    (tick),
    .count   (count)
  );

  tt_flags u_flags (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .ctl_wr (dec.ctl_wr),
    .wdata  (bus_wdata),
    .flags  (flags),
    .irq    (irq_req)
  );

  tt_readback u_rb (
    .clk    (clk),
    .rst    (rst),
    .rd     (dec.rd),
    .rd_sel (dec.rd_sel),
    .flags  (flags),
    .rdata  (bus_rdata)
  );

  assign irq_level = IRQ_LVL_W'(IRQ_LEVEL);

endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int PERIOD = 2,
  parameter int CNT_W  = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [15:0]      bus_wdata,
  input logic [15:0]      bus_rdata,
  input logic             irq_req,
  input logic             tick,
  input logic             ready,
  input logic             enable,
  input logic [CNT_W-1:0] count
);

  p_count_range_r1: assert property (@(posedge clk) disable iff (rst)
    32'(count) < PERIOD);

  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_addr == 2'd1) |=> (count == '0));

  p_enable_load_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == 2'd3) |=> (enable == $past(bus_wdata[0])));

  p_ready_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    tick |=> ready);

  p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> !irq_req);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && enable) |=> irq_req);

  p_tick_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && bus_sel && bus_we && bus_addr == 2'd3 && bus_wdata[13]) |=> ready);

  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> (bus_rdata == '0));

endmodule

bind periodic_tick_timer tt_checker #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_tt_checker (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_req   (irq_req),
  .tick      (tick),
  .ready     (flags.ready),
  .enable    (flags.enable),
  .count     (count)
);

// File: tb/test_periodic_tick_timer.sv
`timescale 1ns/1ps
module test_periodic_tick_timer;

  localparam int SYS_HZ = 5000;
  localparam int TK_HZ  = 50;
  localparam int P      = SYS_HZ / TK_HZ;   // 100 cycles
  localparam int NVEC   = 11;

  // {addr, we, wdata, expected rdata}
  localparam logic [34:0] VEC [NVEC] = '{
    {2'd3, 1'b1, 16'h0001, 16'h0000},  // R6 enable on
    {2'd2, 1'b0, 16'h0000, 16'h0001},  // R5
    {2'd0, 1'b0, 16'h0000, 16'h0000},  // R3 zero read
    {2'd0, 1'b1, 16'hFFFF, 16'h0000},  // R3 ignored write
    {2'd2, 1'b0, 16'h0000, 16'h0001},  // R3
    {2'd2, 1'b1, 16'hFFFF, 16'h0000},  // R3 ignored write
    {2'd2, 1'b0, 16'h0000, 16'h0001},  // R3
    {2'd3, 1'b1, 16'h0000, 16'h0000},  // R6 enable off
    {2'd2, 1'b0, 16'h0000, 16'h0000},  // R5
    {2'd3, 1'b0, 16'h0000, 16'h0000},  // R3 read at 3
    {2'd2, 1'b0, 16'h0000, 16'h0000}   // R3
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_req;
  logic [3:0]  irq_level;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  periodic_tick_timer #(.SYS_CLK_HZ(SYS_HZ), .TICK_HZ(TK_HZ)) i_periodic_tick_timer (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req),
    .irq_level (irq_level)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic access(input logic [1:0] a, input logic w, input logic [15:0] d);
    bus_sel = 1'b1; bus_we = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  // the last access restarted the period; expect the request on edge P
  task automatic expect_pulse(input string req);
    logic early = 1'b0;
    for (int i = 1; i <= P; i++) begin
      @(posedge clk); #1;
      if (i < P && irq_req) early = 1'b1;
    end
    check(req, {15'd0, early}, 16'd0);
    check(req, {15'd0, irq_req}, 16'd1);
    @(posedge clk); #1;
    check("R8 single cycle", {15'd0, irq_req}, 16'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic seen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 rdata", bus_rdata, 16'h0000);
    check("R2 irq", {15'd0, irq_req}, 16'd0);
    rst = 1'b0;
    access(2'd2, 1'b0, 16'h0);
    check("R2 flags clear", bus_rdata, 16'h0000);
    check("R8 level", {12'd0, irq_level}, 16'd13);

    for (int v = 0; v < NVEC; v++) begin
      access(VEC[v][34:33], VEC[v][32], VEC[v][31:16]);
      check($sformatf("R3 R5 R6 vector %0d", v), bus_rdata, VEC[v][15:0]);
    end
    @(posedge clk); #1;
    check("R10 idle rdata", bus_rdata, 16'h0000);
    @(negedge clk);

    // period from a control write, enable on
    access(2'd3, 1'b1, 16'h0001);
    expect_pulse("R1 R8 pulse on edge P");
    access(2'd2, 1'b0, 16'h0);
    check("R7 R5 ready set", bus_rdata, 16'h0009);

    // restart through offset 1
    repeat (40) @(negedge clk);
    access(2'd1, 1'b0, 16'h0);
    check("R4 restart reads zero", bus_rdata, 16'h0000);
    expect_pulse("R4 period restarted");
    access(2'd2, 1'b0, 16'h0);
    check("R4 flags kept", bus_rdata, 16'h0009);

    // clear with bit 13
    access(2'd3, 1'b1, 16'h2001);
    access(2'd2, 1'b0, 16'h0);
    check("R6 clear on bit 13", bus_rdata, 16'h0001);
    repeat (P) @(negedge clk);
    access(2'd3, 1'b1, 16'h0001);   // ready set again by the tick, not cleared
    access(2'd2, 1'b0, 16'h0);
    check("R6 no clear without bit 13", bus_rdata, 16'h0009);

    // collision: last control write at edge w, status read at w+1,
    // clearing write lands on edge w+P
    repeat (P - 2) @(negedge clk);
    access(2'd3, 1'b1, 16'h2001);
    check("R8 collision pulse", {15'd0, irq_req}, 16'd1);
    access(2'd2, 1'b0, 16'h0);
    check("R9 tick wins", bus_rdata, 16'h0009);

    // enable off: ready still sets, no request
    access(2'd3, 1'b1, 16'h2000);
    seen = 1'b0;
    for (int i = 0; i < P + 3; i++) begin
      @(posedge clk); #1;
      if (irq_req) seen = 1'b1;
    end
    check("R8 no request when disabled", {15'd0, seen}, 16'd0);
    @(negedge clk);
    access(2'd2, 1'b0, 16'h0);
    check("R7 ready without enable", bus_rdata, 16'h0008);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule